// File: doc/BRIEF.md
# Indexed Configuration Register Port

This block is the host-facing configuration front end of a local-bus disk controller. A two-bit strap picks one of three groups of I/O addresses. Each group has three byte ports spaced four addresses apart. The first port is a read-only identity byte whose low two bits come from a second strap. The second port holds a register pointer. The third port reads or writes the internal register that the pointer selects.

Behind the pointer sit fifteen byte-wide registers. Most of them are writable settings: global control, byte-transfer timing, mode bits, and per-drive read/write timing, read-ahead count, read-ahead enable and address setup. Two entries are read-only. One returns a fixed silicon revision and the other returns the live value of the read-ahead counter. The stored settings leave the block as decoded fields for the transfer timing and read-ahead logic.

The host bus is a plain synchronous strobe interface. A read strobe on a decoded port returns its byte on `bus_rdata` on the next clock. In any cycle without a decoded read, that output is zero.

Top module: `idx_cfg_port`

## Requirements
- R1: On synchronous reset every writable register, the pointer and `bus_rdata` become 0x00, so every field output is zero.
- R2: Only the group selected by `base_sel` responds: 0 selects 0x034/0x038/0x03C, 1 selects 0x0B4/0x0B8/0x0BC, 2 selects 0xAD4/0xAD8/0xADC, and 3 selects none. Accesses to any other address change nothing and read 0x00.
- R3: A read of the group's first port returns 0x30 plus `id_sel` (0x30..0x33). Writes to that port are ignored.
- R4: A write to the group's second port loads the 8-bit pointer, and a read of that port returns it. The pointer changes only on such a write and never auto-increments.
- R5: A write to the third port with the pointer at a writable index stores the byte. A later read of that port returns it one cycle after the read strobe.
- R6: Writable bit masks are 0x87 for indices 6 and 11 and 0x07 for indices 7, 12 and 15. Masked-out bits read 0 and ignore writes. All other writable indices (1-5, 8-10) keep all 8 bits.
- R7: Index 13 reads as the `REV_ID` parameter and ignores writes.
- R8: Index 14 reads `ra_count_in` as sampled in the read cycle and ignores writes.
- R9: Index 0 and pointer values 16..255 read 0x00, and writes through them change nothing.
- R10: Field outputs follow the registers in the cycle after a write. `ctrl_bits`=idx1 and `byte_time`=idx2. For drive d (base b=3+5d): `drv_rd_time`=idx b and `drv_wr_time`=idx b+1. `drv_ra_count`={idx b+3[1:0], idx b+2}, `drv_ra_en`=idx b+3[7] and `drv_setup`=idx b+4[1:0]. `mode_bits`=idx15[2:0].
- R11: `bus_rdata` is 0x00 in every cycle that does not follow a read of a decoded port.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_sel | input | 2 | Address group strap |
| id_sel | input | 2 | Identity strap, low bits of the ID byte |
| bus_addr | input | 12 | Host I/O address |
| bus_rd | input | 1 | Read strobe |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 8 | Write byte |
| bus_rdata | output | 8 | Registered read byte |
| ra_count_in | input | 8 | Live read-ahead counter value |
| ctrl_bits | output | 8 | Global control register |
| byte_time | output | 8 | Byte-transfer active/recovery counts |
| drv_rd_time | output | 2x8 | Per-drive read timing |
| drv_wr_time | output | 2x8 | Per-drive write timing |
| drv_ra_count | output | 2x10 | Per-drive read-ahead count |
| drv_ra_en | output | 2 | Per-drive read-ahead enable |
| drv_setup | output | 2x2 | Per-drive address setup clocks |
| mode_bits | output | 3 | Mode register bits |

## Verification
The assertions assume that the read and write strobes are never raised in the same cycle. They also assume that the straps change only between accesses, because the identity check compares against the strap value of the strobe cycle. The stimulus drives at most one strobe per cycle and moves the straps only in idle cycles. It sweeps every group setting against all three groups and steps the pointer through 0..19, so read-only, reserved and out-of-range entries are all touched. A behavioural model recomputes the read byte and every field each cycle.

// File: rtl/idxcfg_pkg.sv
package idxcfg_pkg;
  localparam int unsigned BYTE_W  = 8;
  localparam int unsigned NUM_IDX = 16;
  localparam int unsigned NUM_DRV = 2;
  localparam int unsigned DRV_FIRST  = 3;
  localparam int unsigned DRV_STRIDE = 5;
  localparam int unsigned IDX_REV = 13;
  localparam int unsigned IDX_RAC = 14;

  typedef enum logic [1:0] {PORT_NONE, PORT_ID, PORT_PTR, PORT_DATA} port_e;

  function automatic logic [BYTE_W-1:0] wr_mask(input logic [3:0] idx);
    case (idx)
      4'd6, 4'd11:         wr_mask = 8'h87;
      4'd7, 4'd12, 4'd15:  wr_mask = 8'h07;
      4'd0, 4'd13, 4'd14:  wr_mask = 8'h00;
      default:             wr_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/idxcfg_decode.sv
module idxcfg_decode
  import idxcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE0 = 12'h034,
  parameter logic [ADDR_W-1:0] BASE1 = 12'h0B4,
  parameter logic [ADDR_W-1:0] BASE2 = 12'hAD4,
  parameter int unsigned STRIDE = 4
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        grp_sel,
  output port_e             port
);
  localparam logic [ADDR_W-1:0] OFS1 = ADDR_W'(STRIDE);
  localparam logic [ADDR_W-1:0] OFS2 = ADDR_W'(2 * STRIDE);

  logic [ADDR_W-1:0] base;
  logic              grp_on;

  always_comb begin
    grp_on = 1'b1;
    case (grp_sel)
      2'd0:    base = BASE0;
      2'd1:    base = BASE1;
      2'd2:    base = BASE2;
      default: begin base = BASE0; grp_on = 1'b0; end
    endcase
    port = PORT_NONE;
    if (grp_on) begin
      if (addr == base)              port = PORT_ID;
      else if (addr == base + OFS1)  port = PORT_PTR;
      else if (addr == base + OFS2)  port = PORT_DATA;
    end
  end
endmodule

// File: rtl/idxcfg_store.sv
module idxcfg_store
  import idxcfg_pkg::*;
(
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           wr_en,
  input  logic [3:0]                     wr_idx,
  input  logic [BYTE_W-1:0]              wr_data,
  output logic [NUM_IDX-1:0][BYTE_W-1:0] regs
);
  logic [BYTE_W-1:0] mem [NUM_IDX];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NUM_IDX; i++) mem[i] <= '0;
    end else if (wr_en) begin
      mem[wr_idx] <= wr_data & wr_mask(wr_idx);
    end
  end

  for (genvar i = 0; i < NUM_IDX; i++) begin : g_out
    assign regs[i] = mem[i];
  end

  AST_RO_WRITE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_en && (wr_idx == 4'd0 || wr_idx == 4'd13 || wr_idx == 4'd14)) |=> $stable(regs)); // R9
endmodule

// File: rtl/idx_cfg_port.sv
module idx_cfg_port
  import idxcfg_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter logic [ADDR_W-1:0] BASE0 = 12'h034,
  parameter logic [ADDR_W-1:0] BASE1 = 12'h0B4,
  parameter logic [ADDR_W-1:0] BASE2 = 12'hAD4,
  parameter int unsigned STRIDE = 4,
  parameter logic [7:0] REV_ID = 8'h02,
  parameter logic [5:0] ID_HIGH = 6'b001100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        base_sel,
  input  logic [1:0]        id_sel,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_rd,
  input  logic              bus_wr,
  input  logic [7:0]        bus_wdata,
  output logic [7:0]        bus_rdata,
  input  logic [7:0]        ra_count_in,
  output logic [7:0]        ctrl_bits,
  output logic [7:0]        byte_time,
  output logic [1:0][7:0]   drv_rd_time,
  output logic [1:0][7:0]   drv_wr_time,
  output logic [1:0][9:0]   drv_ra_count,
  output logic [1:0]        drv_ra_en,
  output logic [1:0][1:0]   drv_setup,
  output logic [2:0]        mode_bits
);
  port_e                         port;
  logic [BYTE_W-1:0]             ptr_q;
  logic                          ptr_in_range;
  logic                          store_we;
  logic [NUM_IDX-1:0][BYTE_W-1:0] regs;
  logic [BYTE_W-1:0]             rd_val;

  idxcfg_decode #(
    .ADDR_W(ADDR_W), .BASE0(BASE0), .BASE1(BASE1), .BASE2(BASE2), .STRIDE(STRIDE)
  ) u_decode (
    .addr(bus_addr), .grp_sel(base_sel), .port(port)
  );

  always_ff @(posedge clk) begin
    if (rst)                             ptr_q <= '0;
    else if (bus_wr && port == PORT_PTR) ptr_q <= bus_wdata;
  end

  assign ptr_in_range = (ptr_q < BYTE_W'(NUM_IDX));
  assign store_we     = bus_wr && (port == PORT_DATA) && ptr_in_range;

  idxcfg_store u_store (
    .clk(clk), .rst(rst), .wr_en(store_we), .wr_idx(ptr_q[3:0]),
    .wr_data(bus_wdata), .regs(regs)
  );

  always_comb begin
    case (port)
      PORT_ID:  rd_val = {ID_HIGH, id_sel};
      PORT_PTR: rd_val = ptr_q;
      PORT_DATA: begin
        if (!ptr_in_range)                      rd_val = '0;
        else if (ptr_q[3:0] == 4'(IDX_REV))     rd_val = REV_ID;
        else if (ptr_q[3:0] == 4'(IDX_RAC))     rd_val = ra_count_in;
        else                                    rd_val = regs[ptr_q[3:0]];
      end
      default:  rd_val = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)                              bus_rdata <= '0;
    else if (bus_rd && port != PORT_NONE) bus_rdata <= rd_val;
    else                                  bus_rdata <= '0;
  end

  assign ctrl_bits = regs[1];
  assign byte_time = regs[2];
  assign mode_bits = regs[15][2:0];

  for (genvar d = 0; d < NUM_DRV; d++) begin : g_drv
    localparam int unsigned B = DRV_FIRST + d * DRV_STRIDE;
    assign drv_rd_time[d]  = regs[B];
    assign drv_wr_time[d]  = regs[B+1];
    assign drv_ra_count[d] = {regs[B+3][1:0], regs[B+2]};
    assign drv_ra_en[d]    = regs[B+3][7];
    assign drv_setup[d]    = regs[B+4][1:0];
  end

  AST_RW_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && bus_wr)); // R5
  AST_IDLE_RDATA_ZERO: assert property (@(posedge clk) disable iff (rst)
    !(bus_rd && port != PORT_NONE) |=> bus_rdata == 8'h00); // R11
  AST_ID_BYTE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && port == PORT_ID) |=> bus_rdata == {ID_HIGH, $past(id_sel)}); // R3
  AST_REV_BYTE: assert property (@(posedge clk) disable iff (rst)
    (bus_rd && port == PORT_DATA && ptr_q == 8'd13) |=> bus_rdata == REV_ID); // R7
  AST_PTR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && port == PORT_PTR) |=> $stable(ptr_q)); // R4
  AST_NO_GROUP_DEAF: assert property (@(posedge clk) disable iff (rst)
    (base_sel == 2'd3) |-> port == PORT_NONE); // R2
endmodule

// File: tb/idx_cfg_port_tb.sv
module idx_cfg_port_tb;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst = 1'b1;
  logic [1:0]  base_sel = '0, id_sel = '0;
  logic [11:0] bus_addr = '0;
  logic        bus_rd = 1'b0, bus_wr = 1'b0;
  logic [7:0]  bus_wdata = '0, bus_rdata, ra_count_in = '0;
  logic [7:0]  ctrl_bits, byte_time;
  logic [1:0][7:0] drv_rd_time, drv_wr_time;
  logic [1:0][9:0] drv_ra_count;
  logic [1:0]  drv_ra_en;
  logic [1:0][1:0] drv_setup;
  logic [2:0]  mode_bits;

  idx_cfg_port u_dut (
    .clk(clk), .rst(rst), .base_sel(base_sel), .id_sel(id_sel), .bus_addr(bus_addr),
    .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ra_count_in(ra_count_in), .ctrl_bits(ctrl_bits), .byte_time(byte_time),
    .drv_rd_time(drv_rd_time), .drv_wr_time(drv_wr_time), .drv_ra_count(drv_ra_count),
    .drv_ra_en(drv_ra_en), .drv_setup(drv_setup), .mode_bits(mode_bits)
  );

  int checks = 0, errors = 0;
  bit done = 1'b0;

  // behavioural reference model
  logic [7:0] m_reg [16];
  int         m_ptr = 0;
  logic [7:0] exp_rd = 8'h00;
  string      exp_tag = "R1";

  function automatic logic [11:0] grp_base(input int g);
    case (g)
      0: return 12'h034;
      1: return 12'h0B4;
      2: return 12'hAD4;
      default: return 12'hF00;
    endcase
  endfunction

  function automatic logic [7:0] keep_bits(input int idx);
    if (idx == 6 || idx == 11) return 8'h87;
    if (idx == 7 || idx == 12 || idx == 15) return 8'h07;
    if (idx == 0 || idx == 13 || idx == 14 || idx > 15) return 8'h00;
    return 8'hFF;
  endfunction

  initial for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;

  always @(posedge clk) begin
    int sel_port;
    if (rst) begin
      for (int i = 0; i < 16; i++) m_reg[i] = 8'h00;
      m_ptr = 0; exp_rd = 8'h00; exp_tag = "R1";
    end else begin
      sel_port = -1;
      if (base_sel != 2'd3) begin
        if (bus_addr == grp_base(base_sel))      sel_port = 0;
        else if (bus_addr == grp_base(base_sel) + 12'd4) sel_port = 1;
        else if (bus_addr == grp_base(base_sel) + 12'd8) sel_port = 2;
      end
      exp_rd = 8'h00;
      exp_tag = "R11";
      if (bus_rd) begin
        if (sel_port == 0) begin exp_rd = 8'h30 + 8'(id_sel); exp_tag = "R3"; end
        else if (sel_port == 1) begin exp_rd = 8'(m_ptr); exp_tag = "R4"; end
        else if (sel_port == 2) begin
          if (m_ptr == 13) begin exp_rd = 8'h02; exp_tag = "R7"; end
          else if (m_ptr == 14) begin exp_rd = ra_count_in; exp_tag = "R8"; end
          else if (m_ptr == 0 || m_ptr > 15) begin exp_rd = 8'h00; exp_tag = "R9"; end
          else begin
            exp_rd = m_reg[m_ptr];
            exp_tag = (keep_bits(m_ptr) != 8'hFF) ? "R6" : "R5";
          end
        end else exp_tag = "R2";
      end
      if (bus_wr) begin
        if (sel_port == 1) m_ptr = int'(bus_wdata);
        else if (sel_port == 2 && m_ptr < 16)
          m_reg[m_ptr] = bus_wdata & keep_bits(m_ptr);
      end
    end
  end

  always @(negedge clk) begin
    if (!done) begin
      logic [9:0] ra0, ra1;
      checks++;
      if (bus_rdata !== exp_rd) begin
        errors++;
        $display("FAIL %s rdata actual %h expected %h at %0t", exp_tag, bus_rdata, exp_rd, $time);
      end
      ra0 = {m_reg[6][1:0], m_reg[5]};
      ra1 = {m_reg[11][1:0], m_reg[10]};
      checks++;
      if (ctrl_bits !== m_reg[1] || byte_time !== m_reg[2] ||
          drv_rd_time[0] !== m_reg[3] || drv_wr_time[0] !== m_reg[4] ||
          drv_ra_count[0] !== ra0 || drv_ra_en[0] !== m_reg[6][7] ||
          drv_setup[0] !== m_reg[7][1:0] ||
          drv_rd_time[1] !== m_reg[8] || drv_wr_time[1] !== m_reg[9] ||
          drv_ra_count[1] !== ra1 || drv_ra_en[1] !== m_reg[11][7] ||
          drv_setup[1] !== m_reg[12][1:0] || mode_bits !== m_reg[15][2:0]) begin
        errors++;
        $display("FAIL R10 fields actual ctrl=%h rd0=%h ra0=%h mode=%h expected ctrl=%h rd0=%h ra0=%h mode=%h",
                 ctrl_bits, drv_rd_time[0], drv_ra_count[0], mode_bits,
                 m_reg[1], m_reg[3], ra0, m_reg[15][2:0]);
      end
      ra_count_in <= 8'($urandom);
    end
  end

  task automatic bus_cycle(input logic rd, input logic wr, input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_rd = rd; bus_wr = wr; bus_addr = a; bus_wdata = d;
  endtask

  task automatic idle();
    @(negedge clk);
    bus_rd = 1'b0; bus_wr = 1'b0;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // r1_ explicit reset check
    checks++;
    if (bus_rdata !== 8'h00 || ctrl_bits !== 8'h00 || mode_bits !== 3'd0) begin
      errors++;
      $display("FAIL R1 reset actual rdata=%h ctrl=%h expected 00 00", bus_rdata, ctrl_bits);
    end
    for (int bs = 0; bs < 4; bs++) begin
      idle();
      base_sel = 2'(bs);
      for (int ids = 0; ids < 4; ids++) begin
        idle();
        id_sel = 2'(ids);
        for (int g = 0; g < 3; g++) begin
          bus_cycle(1'b1, 1'b0, grp_base(g), 8'h00);             // R3 / R2
          bus_cycle(1'b0, 1'b1, grp_base(g), 8'hFF);             // R3 write ignored
        end
      end
      for (int idx = 0; idx < 20; idx++) begin
        logic [11:0] b;
        b = grp_base(bs == 3 ? 0 : bs);
        bus_cycle(1'b0, 1'b1, b + 12'd4, 8'(idx));               // R4 load pointer
        bus_cycle(1'b1, 1'b0, b + 12'd4, 8'h00);
        bus_cycle(1'b1, 1'b0, b + 12'd8, 8'h00);                 // R5..R9 before write
        bus_cycle(1'b0, 1'b1, b + 12'd8, 8'($urandom) | 8'h78);  // R6 reserved bits set
        idle();
        bus_cycle(1'b1, 1'b0, b + 12'd8, 8'h00);                 // R10 fields next cycle
        bus_cycle(1'b1, 1'b0, b + 12'd4, 8'h00);                 // R4 no auto-increment
        bus_cycle(1'b0, 1'b1, grp_base((bs + 1) % 3) + 12'd8, 8'h5A); // R2 other group
        bus_cycle(1'b1, 1'b0, b + 12'd8, 8'h00);
      end
      for (int k = 0; k < 4; k++) begin
        logic [11:0] b;
        b = grp_base(bs == 3 ? 0 : bs);
        bus_cycle(1'b0, 1'b1, b + 12'd4, 8'd14);                 // R8 live counter
        bus_cycle(1'b1, 1'b0, b + 12'd8, 8'h00);
        bus_cycle(1'b1, 1'b0, b + 12'd8, 8'h00);
        bus_cycle(1'b0, 1'b1, b + 12'd4, 8'd13);                 // R7 revision
        bus_cycle(1'b0, 1'b1, b + 12'd8, 8'hA5);
        bus_cycle(1'b1, 1'b0, b + 12'd8, 8'h00);
      end
    end
    idle();
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule